// File: doc/BRIEF.md
# DMA Burst Planner with Byte Reordering

This block drives one channel of a DMA engine. When a start pulse arrives it takes a snapshot of the channel setup: a burst code, a 16-bit word count, a byte reordering mode and a completion-interrupt enable. It then cuts the count into bus bursts. Before each burst it raises a one-cycle request that carries the beat length. It then moves that many 32-bit words from a read port to a transmit FIFO port. Each word passes through a fixed byte permutation on its way.

The length of each burst is the configured one whenever enough words remain. Near the end of the transfer it drops to the largest of 16, 8, 4 or 1 beats that still fits in the remaining count. A word moves only in a cycle where the read side offers data and the write side can take it. When the last word has moved, the block pulses done. If the interrupt was enabled at start, it also sets a sticky completion flag, which software clears by pulsing a clear input.

Top module: `dma_burst_swap`

## Requirements
- R1: The burst code sets the preferred burst length: 0 gives 1 beat, 1 gives 4, 2 gives 8 and 3 gives 16. While at least that many words remain, each burst uses exactly this length.
- R2: When fewer words remain than the preferred length, the burst takes the largest value in {16, 8, 4, 1} that does not exceed the preferred length or the remaining count. `burst_req` is high for one cycle per burst, and `burst_len` is valid in that cycle.
- R3: Across one transfer, the number of beats moved and the sum of the requested burst lengths both equal the count latched at start.
- R4: Let the input word be {a,b,c,d}, with a in bits 31:24 and d in bits 7:0. Swap mode 0 gives {a,b,c,d}, mode 1 gives {d,c,b,a}, mode 2 gives {c,d,a,b} and mode 3 gives {b,a,d,c}. Words leave in the order they arrive.
- R5: A word transfers only in a cycle where `rd_valid` and `wr_ready` are both high during a burst's data phase. `rd_ready` is high only while `wr_ready` is high, and `wr_valid` is high only while `rd_valid` is high.
- R6: A start with a count of zero raises `done` in the next cycle and issues no burst request.
- R7: `done` is a single-cycle pulse. It comes in the cycle after the cycle in which the final word transferred.
- R8: The completion flag `irq_flag` is set after `done` if the enable latched at start was 1. If that enable was 0, the flag keeps its value.
- R9: A pulse on `irq_clr` clears `irq_flag` on the next edge. When a clear and a set fall in the same cycle, the clear wins.
- R10: Setup is latched at start. While a transfer is in progress, `start` and changes on the setup inputs have no effect on the bursts, the data or the completion.
- R11: After reset, `burst_req`, `done`, `wr_valid`, `rd_ready` and `irq_flag` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a transfer when idle |
| cfg_burst | input | 2 | Preferred burst code |
| cfg_count | input | 16 | Words to move |
| cfg_swap | input | 2 | Byte reordering mode |
| cfg_irq_en | input | 1 | Completion-interrupt enable |
| rd_data | input | 32 | Word from the read port |
| rd_valid | input | 1 | Read word available |
| rd_ready | output | 1 | Read word consumed |
| wr_data | output | 32 | Reordered word toward the FIFO |
| wr_valid | output | 1 | Write word available |
| wr_ready | input | 1 | FIFO can accept |
| burst_req | output | 1 | One-cycle burst request |
| burst_len | output | 5 | Beats in the requested burst |
| done | output | 1 | Transfer finished pulse |
| irq_clr | input | 1 | Clears the completion flag |
| irq_flag | output | 1 | Sticky completion flag |

## Verification
The first directed counts are picked so that the burst sequence shows the fallback rule directly. A count of 37 at code 3 must give 16, 16, 4, 1. A count of 3 at code 1 must give three single beats. A count of 8 at code 2 must give one full burst. A count of zero must give done with no burst at all. Random counts, codes and swap modes with random valid/ready stalls then separate correct lane reordering and word ordering from errors where beats are dropped or duplicated while the handshake stalls. Further runs set a clear in the same cycle as the done pulse, turn the enable off while the flag is already set, and fire a stray start with different setup in the middle of a transfer. These runs tell the clear priority, the sticky flag and setup latching apart from the plain completion path.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    parameter int CNT_W  = 16;
    parameter int LEN_W  = 5;
    parameter int WORD_W = 32;
    localparam int BYTE_N = WORD_W / 8;
    localparam int LANE_W = $clog2(BYTE_N);

    typedef enum logic [1:0] {
        BC_SINGLE = 2'd0,
        BC_B4     = 2'd1,
        BC_B8     = 2'd2,
        BC_B16    = 2'd3
    } burst_code_e;

    typedef enum logic [1:0] {
        SW_KEEP = 2'd0,
        SW_REV  = 2'd1,
        SW_HALF = 2'd2,
        SW_PAIR = 2'd3
    } swap_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DATA = 2'd2,
        ST_FIN  = 2'd3
    } state_e;

    typedef struct packed {
        burst_code_e        burst;
        swap_e              swap;
        logic               irq_en;
        logic [CNT_W-1:0]   count;
    } cfg_t;

    // Beat length of a burst code.
    function automatic logic [LEN_W-1:0] code_len(burst_code_e c);
        case (c)
            BC_SINGLE: code_len = LEN_W'(1);
            BC_B4:     code_len = LEN_W'(4);
            BC_B8:     code_len = LEN_W'(8);
            default:   code_len = LEN_W'(16);
        endcase
    endfunction

    // Largest code length not above the cap nor the remaining count.
    function automatic logic [LEN_W-1:0] pick_len(burst_code_e cap_code,
                                                  logic [CNT_W-1:0] rem);
        logic [LEN_W-1:0] cap;
        logic [LEN_W-1:0] cand;
        cap      = code_len(cap_code);
        pick_len = LEN_W'(1);
        for (int i = 0; i < 4; i++) begin
            cand = code_len(burst_code_e'(2'(i)));
            if (cand <= cap && rem >= CNT_W'(cand))
                pick_len = cand;
        end
    endfunction

    // Source lane for output lane k: each mode is an XOR of the lane index.
    function automatic logic [LANE_W-1:0] lane_mask(swap_e m);
        case (m)
            SW_KEEP: lane_mask = LANE_W'(0);
            SW_REV:  lane_mask = LANE_W'(3);
            SW_HALF: lane_mask = LANE_W'(2);
            default: lane_mask = LANE_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/dbs_byte_swap.sv
module dbs_byte_swap
    import dbs_pkg::*;
(
    input  swap_e              mode,
    input  logic [WORD_W-1:0]  din,
    output logic [WORD_W-1:0]  dout
);

    logic [LANE_W-1:0] mask;
    assign mask = lane_mask(mode);

    for (genvar k = 0; k < BYTE_N; k++) begin : g_lane
        logic [LANE_W-1:0] src;
        assign src = LANE_W'(k) ^ mask;
        assign dout[k*8 +: 8] = din[src*8 +: 8];
    end

endmodule

// File: rtl/dbs_burst_planner.sv
module dbs_burst_planner
    import dbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  cfg_t              cfg_in,
    input  logic              burst_last,
    output logic              busy,
    output logic              burst_req,
    output logic [LEN_W-1:0]  burst_len,
    output logic              data_phase,
    output logic              done,
    output swap_e             swap_mode,
    output logic              irq_en
);

    state_e             state_q;
    cfg_t               cfg_q;
    logic [CNT_W-1:0]   rem_q;

    assign burst_len  = pick_len(cfg_q.burst, rem_q);
    assign burst_req  = (state_q == ST_REQ);
    assign data_phase = (state_q == ST_DATA);
    assign done       = (state_q == ST_FIN);
    assign busy       = (state_q != ST_IDLE);
    assign swap_mode  = cfg_q.swap;
    assign irq_en     = cfg_q.irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            rem_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q   <= cfg_in;
                        rem_q   <= cfg_in.count;
                        state_q <= (cfg_in.count == '0) ? ST_FIN : ST_REQ;
                    end
                end
                ST_REQ: begin
                    rem_q   <= rem_q - CNT_W'(burst_len);
                    state_q <= ST_DATA;
                end
                ST_DATA: begin
                    if (burst_last)
                        state_q <= (rem_q == '0) ? ST_FIN : ST_REQ;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dbs_beat_counter.sv
module dbs_beat_counter
    import dbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              fire,
    output logic              last
);

    logic [LEN_W-1:0] left_q;

    assign last = fire && (left_q == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (load)
            left_q <= load_len;
        else if (fire && left_q != '0)
            left_q <= left_q - LEN_W'(1);
    end

endmodule

// File: rtl/dbs_irq_status.sv
module dbs_irq_status (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (clr)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
    end

endmodule

// File: rtl/dma_burst_swap.sv
module dma_burst_swap
    import dbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        cfg_burst,
    input  logic [15:0]       cfg_count,
    input  logic [1:0]        cfg_swap,
    input  logic              cfg_irq_en,
    input  logic [31:0]       rd_data,
    input  logic              rd_valid,
    output logic              rd_ready,
    output logic [31:0]       wr_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic              burst_req,
    output logic [4:0]        burst_len,
    output logic              done,
    input  logic              irq_clr,
    output logic              irq_flag
);

    cfg_t   cfg_in;
    logic   busy;
    logic   data_phase;
    logic   fire;
    logic   burst_last;
    swap_e  swap_mode;
    logic   irq_en;

    assign cfg_in.burst  = burst_code_e'(cfg_burst);
    assign cfg_in.swap   = swap_e'(cfg_swap);
    assign cfg_in.irq_en = cfg_irq_en;
    assign cfg_in.count  = cfg_count;

    assign fire     = data_phase && rd_valid && wr_ready;
    assign rd_ready = data_phase && wr_ready;
    assign wr_valid = data_phase && rd_valid;

    dbs_burst_planner planner_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cfg_in     (cfg_in),
        .burst_last (burst_last),
        .busy       (busy),
        .burst_req  (burst_req),
        .burst_len  (burst_len),
        .data_phase (data_phase),
        .done       (done),
        .swap_mode  (swap_mode),
        .irq_en     (irq_en)
    );

    dbs_beat_counter beats_i (
        .clk      (clk),
        .rst      (rst),
        .load     (burst_req),
        .load_len (burst_len),
        .fire     (fire),
        .last     (burst_last)
    );

    dbs_byte_swap swap_i (
        .mode (swap_mode),
        .din  (rd_data),
        .dout (wr_data)
    );

    dbs_irq_status irq_i (
        .clk  (clk),
        .rst  (rst),
        .set  (done && irq_en),
        .clr  (irq_clr),
        .flag (irq_flag)
    );

endmodule

// File: rtl/dma_burst_swap_chk.sv
module dma_burst_swap_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic [15:0] cfg_count,
    input logic        burst_req,
    input logic [4:0]  burst_len,
    input logic        rd_valid,
    input logic        rd_ready,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic        done,
    input logic        irq_clr,
    input logic        irq_flag
);

    logic [16:0] moved_q;
    logic [15:0] want_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            moved_q <= '0;
            want_q  <= '0;
        end else if (start && !busy) begin
            moved_q <= '0;
            want_q  <= cfg_count;
        end else if (wr_valid && wr_ready) begin
            moved_q <= moved_q + 17'd1;
        end
    end

    assert_len_legal_R2: assert property (@(posedge clk) disable iff (rst)
        burst_req |-> ($countones(burst_len) == 1 && burst_len != 5'd2));

    assert_req_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        burst_req |=> !burst_req);

    assert_beats_total_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (moved_q == {1'b0, want_q}));

    assert_handshake_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |-> (rd_valid && rd_ready));

    assert_zero_count_R6: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && cfg_count == 16'd0) |=> (done && !burst_req));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_clr_wins_R9: assert property (@(posedge clk) disable iff (rst)
        irq_clr |=> !irq_flag);

endmodule

bind dma_burst_swap dma_burst_swap_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .cfg_count (cfg_count),
    .burst_req (burst_req),
    .burst_len (burst_len),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .done      (done),
    .irq_clr   (irq_clr),
    .irq_flag  (irq_flag)
);

// File: tb/dma_burst_swap_tb_top.sv
module dma_burst_swap_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [1:0]  cfg_burst;
    logic [15:0] cfg_count;
    logic [1:0]  cfg_swap;
    logic        cfg_irq_en;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        rd_ready;
    logic [31:0] wr_data;
    logic        wr_valid;
    logic        wr_ready;
    logic        burst_req;
    logic [4:0]  burst_len;
    logic        done;
    logic        irq_clr;
    logic        irq_flag;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit flag_model = 0;
    int unsigned seed_base = 32'h5eed1234;

    always #2.5 clk = ~clk;

    dma_burst_swap dut_i (
        .clk(clk), .rst(rst), .start(start),
        .cfg_burst(cfg_burst), .cfg_count(cfg_count), .cfg_swap(cfg_swap),
        .cfg_irq_en(cfg_irq_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .burst_req(burst_req), .burst_len(burst_len),
        .done(done), .irq_clr(irq_clr), .irq_flag(irq_flag)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: run hung, act=%0d exp<=150000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [1:0] bc, input int rem);
        int cap, m;
        cap = (bc == 2'd0) ? 1 : (4 << (bc - 1));
        m = (cap < rem) ? cap : rem;
        if (m >= 16) return 16;
        if (m >= 8)  return 8;
        if (m >= 4)  return 4;
        return 1;
    endfunction

    function automatic logic [31:0] exp_swap(input logic [1:0] m, input logic [31:0] w);
        logic [7:0] a, b, c, d;
        {a, b, c, d} = w;
        case (m)
            2'd0: return {a, b, c, d};
            2'd1: return {d, c, b, a};
            2'd2: return {c, d, a, b};
            default: return {b, a, d, c};
        endcase
    endfunction

    function automatic logic [31:0] src_word(input int i, input int unsigned salt);
        return (32'h9E3779B9 * (i + 1)) ^ salt;
    endfunction

    task automatic run_xfer(input logic [1:0] bc, input int cnt, input logic [1:0] sm,
                            input bit ien, input bit clr_on_done, input bit poke);
        int rem, left, fired, cyc, sum_len;
        bit exp_done, f;
        int unsigned salt;
        salt = $urandom;
        @(negedge clk);
        cfg_burst = bc; cfg_count = 16'(cnt); cfg_swap = sm; cfg_irq_en = ien;
        start = 1'b1; rd_valid = 1'b0; wr_ready = 1'b0;
        rem = cnt; left = 0; fired = 0; cyc = 0; sum_len = 0;
        exp_done = (cnt == 0);
        forever begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            if (poke && cyc == 3 && !exp_done) begin
                start = 1'b1; cfg_count = 16'(cnt) ^ 16'h0055;
                cfg_burst = ~bc; cfg_swap = ~sm; cfg_irq_en = ~ien;
            end
            rd_valid = ($urandom % 4) != 0;
            wr_ready = ($urandom % 4) != 0;
            rd_data  = src_word(fired, salt);
            irq_clr  = exp_done && clr_on_done;
            #1;
            chk(!rd_ready || wr_ready, "R5", "rd_ready without wr_ready", rd_ready, wr_ready);
            chk(!wr_valid || rd_valid, "R5", "wr_valid without rd_valid", wr_valid, rd_valid);
            if (burst_req) begin
                chk(left == 0 && !exp_done, "R2", "burst request out of place", left, 0);
                chk(burst_len == 5'(exp_len(bc, rem)), (rem >= exp_len(bc, 65535)) ? "R1" : "R2",
                    "burst length", burst_len, exp_len(bc, rem));
                left = exp_len(bc, rem);
                rem -= left;
                sum_len += left;
            end
            f = wr_valid && wr_ready;
            if (f) begin
                chk(left > 0, "R5", "beat outside burst", left, 1);
                chk(wr_data == exp_swap(sm, src_word(fired, salt)), "R4", "swapped word",
                    wr_data, exp_swap(sm, src_word(fired, salt)));
                fired++;
                left--;
            end
            chk(done == exp_done, exp_done ? "R7" : "R7", "done timing", done, exp_done);
            if (exp_done) break;
            exp_done = f && left == 0 && rem == 0;
            if (cyc > 20000) begin
                chk(1'b0, "R3", "transfer stalled", fired, cnt);
                break;
            end
        end
        chk(fired == cnt, poke ? "R10" : "R3", "beats moved", fired, cnt);
        chk(sum_len == cnt, (cnt == 0) ? "R6" : "R3", "sum of burst lengths", sum_len, cnt);
        if (clr_on_done) flag_model = 0;
        else if (ien) flag_model = 1;
        @(negedge clk);
        irq_clr = 1'b0; rd_valid = 1'b0; wr_ready = 1'b0;
        #1;
        chk(irq_flag == flag_model, clr_on_done ? "R9" : "R8", "completion flag", irq_flag, flag_model);
        chk(done == 1'b0, "R7", "done held high", done, 0);
    endtask

    initial begin
        void'($urandom(seed_base));
        rst = 1'b1; start = 0; cfg_burst = 0; cfg_count = 0; cfg_swap = 0;
        cfg_irq_en = 0; rd_data = 0; rd_valid = 0; wr_ready = 0; irq_clr = 0;
        repeat (4) @(negedge clk);
        rd_valid = 1; wr_ready = 1;
        #1;
        chk(!burst_req && !done && !wr_valid && !rd_ready && !irq_flag, "R11",
            "reset outputs", {burst_req, done, wr_valid, rd_ready, irq_flag}, 0);
        @(negedge clk);
        rst = 1'b0; rd_valid = 0; wr_ready = 0;

        run_xfer(2'd3, 37, 2'd1, 1'b0, 1'b0, 1'b0);  // R1 R2: 16,16,4,1
        run_xfer(2'd2, 8,  2'd2, 1'b0, 1'b0, 1'b0);  // R1: one 8-beat burst
        run_xfer(2'd1, 3,  2'd3, 1'b0, 1'b0, 1'b0);  // R2: three singles
        run_xfer(2'd0, 5,  2'd0, 1'b0, 1'b0, 1'b0);  // R1: single beats
        run_xfer(2'd3, 0,  2'd0, 1'b1, 1'b0, 1'b0);  // R6 and R8 set
        run_xfer(2'd2, 12, 2'd1, 1'b0, 1'b0, 1'b0);  // R8: flag stays set
        @(negedge clk); irq_clr = 1'b1;               // R9 standalone clear
        @(negedge clk); irq_clr = 1'b0; #1;
        flag_model = 0;
        chk(irq_flag == 1'b0, "R9", "clear pulse", irq_flag, 0);
        run_xfer(2'd1, 9,  2'd2, 1'b1, 1'b1, 1'b0);  // R9: clear beats set
        run_xfer(2'd3, 21, 2'd3, 1'b1, 1'b0, 1'b1);  // R10: stray start ignored
        for (int i = 0; i < 25; i++)
            run_xfer(2'($urandom % 4), int'($urandom % 70), 2'($urandom % 4),
                     1'($urandom % 2), ($urandom % 5) == 0, ($urandom % 4) == 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule